// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus (SMBus-style framing) that holds a small bank of 8-bit configuration registers for a clock generator. A bus master reaches the bank with four transfer types: write of one indexed byte, read of one indexed byte, write of a counted block starting at register 0, and read of a block that begins with a byte count. The first byte after the address, the command byte, picks the transfer type in its top bit, carries a two-bit chip-select field that has to be zero, and in its low five bits gives the register index for single-byte access.

Both bus lines are oversampled by a fast system clock through a two-stage synchronizer and a small majority filter, and start, repeated start and stop are found from the filtered lines. The slave pulls SDA low only, through an active-high enable, and releases it during every bit the master drives. The full bank is presented as a flat parallel output, and the output-enable and spread-control fields are also brought out as separate pins. The top register is a fixed identification byte: upper nibble revision, lower nibble vendor code.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset the bank holds register 0 = 0x78, 1 = 0x00, 2 = 0x00, 3 = 0xAF, 4 = 0x01, 5 = 0x00, 6 = 0x13 and 7 = 0x01; `regs_o` carries register k in bits 8k+7 down to 8k.
- R2: The slave acknowledges an address byte of 0xD2 (write) or 0xD3 (read), that is 7-bit address 0x69 plus the direction bit. Any other address is not acknowledged and has no effect on the bank.
- R3: Command bits 6:5 form a chip-select field. When it is not 00 the command byte is not acknowledged, the rest of the transfer is ignored and the bank does not change.
- R4: A single-byte write (command bit 7 = 1, index in bits 4:0) acknowledges the command and the data byte, and stores the data byte, received MSB first, in the indexed register.
- R5: A single-byte read (command with bit 7 = 1, repeated start, then 0xD3) returns the indexed register MSB first.
- R6: A block write (command 0x00, then a count byte, then data bytes) acknowledges every byte and stores the data bytes in registers 0, 1, 2 and on, in order.
- R7: A block read (command 0x00, repeated start, 0xD3) returns first the count 8, then registers 0 to 7 in ascending order, one per master ACK, and stops sending after the master's NACK.
- R8: A block command whose bits 4:0 are not zero, or a single-byte command with an index of 8 or more, is not acknowledged and changes nothing.
- R9: Register 7 is read-only: a write to it is acknowledged but its value stays 0x01 on `regs_o` and in reads.
- R10: Data bytes past the byte count of a block write, and any second data byte of a single-byte write, are not acknowledged and not stored.
- R11: A stop after any complete data byte ends the transfer and keeps every byte already stored; the registers not yet reached keep their values.
- R12: `clk_oe_o[i]` equals register 0 bit 3+i, `ss_en_o` equals register 2 bit 0 and `ss_sel_o` equals register 2 bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset, loads register defaults |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | High to pull SDA low |
| regs_o | output | 64 | Whole register bank, register k in bits 8k+7:8k |
| clk_oe_o | output | 4 | Per-output clock enables from register 0 |
| ss_en_o | output | 1 | Spread enable from register 2 |
| ss_sel_o | output | 1 | Spread depth select from register 2 |

## Verification
The assertions take for granted a well-behaved master: SDA changes only while SCL has been low for longer than the synchronizer and filter delay, and no start or stop is issued while the slave is driving an acknowledge or a read bit. Under that assumption the slave's enable and the bank may only change while the raw SCL pin is low, and a register may only change right after a master-driven bit. The bench keeps within this by moving SDA a quarter bit after each SCL edge, with a quarter bit of many system clocks, and it ends every read with a NACK before the stop.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NREG = 8,
  parameter int FLT = 3,
  parameter logic [7:0] ID_BYTE = 8'h01,
  parameter logic [8*NREG-1:0] DEFAULTS = 64'h01_13_00_01_AF_00_00_78
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [8*NREG-1:0] regs_o,
  output logic [3:0]       clk_oe_o,
  output logic             ss_en_o,
  output logic             ss_sel_o
);
  localparam int IW = $clog2(NREG);
  localparam logic [7:0] NREG8 = 8'(NREG);

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RACK, ST_TX, ST_TACK, ST_IGN} st_t;
  typedef enum logic [1:0] {PH_ADDR, PH_CMD, PH_CNT, PH_DATA} ph_t;

  logic [1:0] scl_s, sda_s;
  logic [FLT-1:0] scl_h, sda_h;
  logic scl_f, sda_f, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[FLT-2:0], scl_s[1]};
      sda_h <= {sda_h[FLT-2:0], sda_s[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_c  = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_c   = scl_f & scl_q & ~sda_q & sda_f;

  st_t st;
  ph_t ph;
  logic [7:0] sh, ptr, cnt;
  logic [3:0] bitcnt;
  logic blk, rd, cnt_sent, more, ok;
  logic [7:0] mem [NREG-1];
  logic [7:0] rdata, tx_byte;

  for (genvar g = 0; g < NREG-1; g++) begin : g_out
    assign regs_o[8*g +: 8] = mem[g];
  end
  assign regs_o[8*(NREG-1) +: 8] = ID_BYTE;

  assign clk_oe_o = regs_o[6:3];
  assign ss_en_o  = regs_o[16];
  assign ss_sel_o = regs_o[23];

  assign rdata   = (ptr < NREG8) ? regs_o[{ptr[IW-1:0], 3'b000} +: 8] : 8'hFF;
  assign tx_byte = (blk && !cnt_sent) ? NREG8 : rdata;

  always_comb begin
    case (ph)
      PH_ADDR: ok = (sh[7:1] == DEV_ADDR);
      PH_CMD:  ok = (sh[6:5] == 2'b00) &&
                    (sh[7] ? ({3'b000, sh[4:0]} < NREG8) : (sh[4:0] == 5'd0));
      PH_CNT:  ok = 1'b1;
      default: ok = (ptr < NREG8) && (cnt != 8'd0);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= PH_ADDR; sh <= '0; ptr <= '0; cnt <= '0;
      bitcnt <= '0; blk <= 1'b0; rd <= 1'b0; cnt_sent <= 1'b0; more <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG-1; i++) mem[i] <= DEFAULTS[8*i +: 8];
    end else if (start_c) begin
      st <= ST_RX; ph <= PH_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      st <= ST_IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_RX:
          if (scl_rise && bitcnt < 4'd8) begin
            sh <= {sh[6:0], sda_f};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (!ok) st <= ST_IGN;
            else begin
              sda_oe <= 1'b1;
              st <= ST_RACK;
              case (ph)
                PH_ADDR: rd <= sh[0];
                PH_CMD: begin
                  blk <= ~sh[7];
                  ptr <= sh[7] ? {3'b000, sh[4:0]} : 8'd0;
                  cnt <= 8'd1;
                  cnt_sent <= 1'b0;
                end
                PH_CNT: cnt <= sh;
                default: begin
                  if (ptr != NREG8 - 8'd1) mem[ptr[IW-1:0]] <= sh;
                  ptr <= ptr + 8'd1;
                  cnt <= cnt - 8'd1;
                end
              endcase
            end
          end
        ST_RACK:
          if (scl_fall) begin
            if (ph == PH_ADDR && rd) begin
              sh <= tx_byte; sda_oe <= ~tx_byte[7]; bitcnt <= 4'd1; st <= ST_TX;
              if (blk && !cnt_sent) cnt_sent <= 1'b1; else ptr <= ptr + 8'd1;
            end else begin
              sda_oe <= 1'b0; st <= ST_RX; bitcnt <= '0;
              case (ph)
                PH_ADDR: ph <= PH_CMD;
                PH_CMD:  ph <= blk ? PH_CNT : PH_DATA;
                default: ph <= PH_DATA;
              endcase
            end
          end
        ST_TX:
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0; st <= ST_TACK;
            end else begin
              sda_oe <= ~sh[6];
              sh <= {sh[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end
          end
        ST_TACK:
          if (scl_rise) more <= ~sda_f;
          else if (scl_fall) begin
            if (more) begin
              sh <= tx_byte; sda_oe <= ~tx_byte[7]; bitcnt <= 4'd1; st <= ST_TX;
              if (blk && !cnt_sent) cnt_sent <= 1'b1; else ptr <= ptr + 8'd1;
            end else st <= ST_IGN;
          end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
  parameter int NREG = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_oe,
  input logic [8*NREG-1:0] regs_o
);
  p_id_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(regs_o[8*(NREG-1) +: 8]));

  p_oe_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  p_bank_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> !scl_i);

  p_write_after_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> !$past(sda_oe));
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .regs_o(regs_o)
);

// File: tb/sim_smb_cfg_slave.sv
`timescale 1ns/1ps
module sim_smb_cfg_slave;
  localparam int Q = 25;
  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, m_low = 1'b0;
  logic sda_oe, ss_en_o, ss_sel_o;
  logic [63:0] regs_o;
  logic [3:0] clk_oe_o;
  wire sda_bus = ~(sda_oe | m_low);
  int nvec = 0, nbad = 0;
  bit done = 1'b0;
  logic [7:0] exp_r [8] = '{8'h78, 8'h00, 8'h00, 8'hAF, 8'h01, 8'h00, 8'h13, 8'h01};

  always #2.5 clk = ~clk;

  smb_cfg_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .regs_o(regs_o), .clk_oe_o(clk_oe_o),
    .ss_en_o(ss_en_o), .ss_sel_o(ss_sel_o));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = exp_r[i];
    return v;
  endfunction

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask
  task automatic bstart();
    m_low = 0; wt(Q); scl_m = 1; wt(Q); m_low = 1; wt(Q); scl_m = 0; wt(Q);
  endtask
  task automatic bstop();
    m_low = 1; wt(Q); scl_m = 1; wt(Q); m_low = 0; wt(Q);
  endtask
  task automatic wbit(input logic b);
    m_low = ~b; wt(Q); scl_m = 1; wt(2*Q); scl_m = 0; wt(Q);
  endtask
  task automatic rbit(output logic b);
    m_low = 0; wt(Q); scl_m = 1; wt(Q); b = sda_bus; wt(Q); scl_m = 0; wt(Q);
  endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b); ack = ~b;
  endtask
  task automatic rbyte(input logic ackit, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(~ackit);
  endtask

  task automatic rd_single(input logic [7:0] cmd, output logic [7:0] d);
    logic a;
    bstart(); wbyte(8'hD2, a); wbyte(cmd, a);
    bstart(); wbyte(8'hD3, a); rbyte(1'b0, d); bstop();
  endtask

  task automatic t_reset();
    chk("R1 defaults", regs_o, model());
    chk("R12 clk_oe reset", {60'd0, clk_oe_o}, 64'hF);
    chk("R12 spread reset", {62'd0, ss_en_o, ss_sel_o}, 64'd0);
  endtask

  task automatic t_addr();
    logic a;
    bstart(); wbyte(8'hA4, a); bstop();
    chk("R2 foreign address nack", {63'd0, a}, 64'd0);
    chk("R2 bank unchanged", regs_o, model());
  endtask

  task automatic t_byte_wr();
    logic a0, a1, a2;
    bstart(); wbyte(8'hD2, a0); wbyte(8'h82, a1); wbyte(8'h81, a2); bstop();
    exp_r[2] = 8'h81;
    chk("R2 address ack", {63'd0, a0}, 64'd1);
    chk("R4 cmd and data ack", {62'd0, a1, a2}, 64'd3);
    chk("R4 stored", regs_o, model());
    chk("R12 spread pins", {62'd0, ss_en_o, ss_sel_o}, 64'd3);
  endtask

  task automatic t_byte_rd();
    logic [7:0] d;
    rd_single(8'h83, d); chk("R5 read reg3", {56'd0, d}, 64'hAF);
    rd_single(8'h82, d); chk("R5 read reg2", {56'd0, d}, 64'h81);
  endtask

  task automatic t_block_wr();
    logic a, all;
    all = 1;
    bstart(); wbyte(8'hD2, a); all &= a; wbyte(8'h00, a); all &= a;
    wbyte(8'd3, a); all &= a;
    wbyte(8'h11, a); all &= a; wbyte(8'h22, a); all &= a; wbyte(8'h33, a); all &= a;
    bstop();
    exp_r[0] = 8'h11; exp_r[1] = 8'h22; exp_r[2] = 8'h33;
    chk("R6 all bytes acked", {63'd0, all}, 64'd1);
    chk("R6 stored ascending", regs_o, model());
    chk("R12 clk_oe from reg0", {60'd0, clk_oe_o}, 64'h2);
  endtask

  task automatic t_block_rd();
    logic a;
    logic [7:0] d;
    bstart(); wbyte(8'hD2, a); wbyte(8'h00, a);
    bstart(); wbyte(8'hD3, a);
    chk("R2 read address ack", {63'd0, a}, 64'd1);
    rbyte(1'b1, d); chk("R7 count byte", {56'd0, d}, 64'd8);
    for (int i = 0; i < 8; i++) begin
      rbyte(i != 7, d);
      chk($sformatf("R7 block byte %0d", i), {56'd0, d}, {56'd0, exp_r[i]});
    end
    bstop();
    rd_single(8'h81, d); chk("R7 idle after nack", {56'd0, d}, {56'd0, exp_r[1]});
  endtask

  task automatic t_cs();
    logic a, c;
    bstart(); wbyte(8'hD2, a); wbyte(8'hA1, c); wbyte(8'h5A, a); bstop();
    chk("R3 chip select nack", {63'd0, c}, 64'd0);
    bstart(); wbyte(8'hD2, a); wbyte(8'h20, c); wbyte(8'd1, a); wbyte(8'h5A, a); bstop();
    chk("R3 block chip select nack", {63'd0, c}, 64'd0);
    chk("R3 bank unchanged", regs_o, model());
  endtask

  task automatic t_off();
    logic a, c1, c2;
    bstart(); wbyte(8'hD2, a); wbyte(8'h05, c1); wbyte(8'd1, a); bstop();
    bstart(); wbyte(8'hD2, a); wbyte(8'h88, c2); wbyte(8'h77, a); bstop();
    chk("R8 bad offsets nack", {62'd0, c1, c2}, 64'd0);
    chk("R8 bank unchanged", regs_o, model());
  endtask

  task automatic t_id();
    logic a;
    logic [7:0] d;
    bstart(); wbyte(8'hD2, a); wbyte(8'h87, a); wbyte(8'h55, a); bstop();
    chk("R9 id write acked", {63'd0, a}, 64'd1);
    chk("R9 id unchanged", regs_o, model());
    rd_single(8'h87, d); chk("R9 id readback", {56'd0, d}, 64'h01);
  endtask

  task automatic t_count();
    logic a, a1, a2;
    bstart(); wbyte(8'hD2, a); wbyte(8'h00, a); wbyte(8'd1, a);
    wbyte(8'h44, a1); wbyte(8'h66, a2); bstop();
    exp_r[0] = 8'h44;
    chk("R10 block acks", {62'd0, a1, a2}, 64'd2);
    chk("R10 excess not stored", regs_o, model());
    bstart(); wbyte(8'hD2, a); wbyte(8'h84, a); wbyte(8'h12, a1); wbyte(8'h34, a2); bstop();
    exp_r[4] = 8'h12;
    chk("R10 single second nack", {62'd0, a1, a2}, 64'd2);
    chk("R10 single one byte", regs_o, model());
  endtask

  task automatic t_stop();
    logic a;
    logic [7:0] d;
    bstart(); wbyte(8'hD2, a); wbyte(8'h00, a); wbyte(8'd4, a); wbyte(8'hA5, a); bstop();
    exp_r[0] = 8'hA5;
    chk("R11 partial block kept", regs_o, model());
    rd_single(8'h81, d); chk("R11 later reg intact", {56'd0, d}, {56'd0, exp_r[1]});
  endtask

  initial begin
    wt(10); rst_n = 1; wt(10);
    t_reset(); t_addr(); t_byte_wr(); t_byte_rd(); t_block_wr(); t_block_rd();
    t_cs(); t_off(); t_id(); t_count(); t_stop();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule